// File: doc/BRIEF.md
# Jet Hit Multiplicity Tally

This block takes one frame of packed jet region words per clock and, for each jet threshold, counts how many words in the frame report a pass. Every word has three fields: a coarse position, one pass bit per threshold, and a saturation flag. The counts are three bits wide and stop at their largest value. A frame-level saturation flag is raised when any word carries its saturation flag, and in that case every count is forced to its largest value.

The block sits behind a link receiver on a 160 MHz domain. When the frame-valid input is high, the block registers the counts, the saturation flag and the position fields. It raises an output strobe on the next clock. When frame-valid is low, the result registers keep their last values.

Top module: `jet_hit_tally`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_counts`, `out_sat` and `out_pos` are all cleared to zero at that edge.
- R2: `out_valid` at each clock edge takes the value `in_valid` had at the previous edge, so it lags `in_valid` by exactly one clock.
- R3: Word i occupies `in_words[11*i+10 : 11*i]`. Inside a word, bit 0 is the saturation flag, bits 8:1 are the pass bits for thresholds 0 to 7 (threshold k in bit k+1), and bits 10:9 are the position. Count k is placed in `out_counts[3*k+2 : 3*k]`. It equals the number of words in an accepted frame whose bit k+1 is set.
- R4: A count whose true value is above 7 is reported as 7. For example, eight words that all pass a threshold give 7.
- R5: If bit 0 of any word in an accepted frame is set, `out_sat` becomes 1 and all eight counts become 7. Otherwise `out_sat` becomes 0.
- R6: For an accepted frame, `out_pos[2*i+1 : 2*i]` takes bits 10:9 of word i. This holds whether or not the frame is saturated.
- R7: The position bits of a word have no effect on any count or on `out_sat`.
- R8: When `in_valid` is low, `out_counts`, `out_sat` and `out_pos` keep their previous values, whatever is on `in_words`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame present on `in_words` |
| in_words | input | 88 | Eight packed 11-bit region words |
| out_valid | output | 1 | Result strobe, one clock after an accepted frame |
| out_counts | output | 24 | Eight saturating 3-bit counts, count k in bits 3k+2:3k |
| out_sat | output | 1 | Frame carried a saturation flag |
| out_pos | output | 16 | Registered position field of each word |

## Verification
Two limits on a count can apply to the same accepted frame. One is saturation of the count itself, when a threshold passes in all eight words. The other is the override from a word's saturation flag. The bench provokes this with frames where every pass bit is set and a single saturation flag is set in a different word each time, and also with frames where only the override applies. Each count must read 7 through either path, and `out_pos` must still carry the positions of that frame. A behavioural model computes the expected fields with plain integer arithmetic and compares them with the design on every clock, including idle clocks where words change and nothing may move.

// File: rtl/jht_pkg.sv
package jht_pkg;
  parameter int JHT_WORDS = 8;
  parameter int JHT_THR   = 8;
  parameter int JHT_POS_W = 2;
  parameter int JHT_CNT_W = 3;
endpackage

// File: rtl/jht_unpack.sv
module jht_unpack #(
  parameter int N_WORDS = 8,
  parameter int N_THR   = 8,
  parameter int POS_W   = 2,
  localparam int WORD_W = POS_W + N_THR + 1
) (
  input  logic [N_WORDS*WORD_W-1:0] words,
  output logic [N_THR*N_WORDS-1:0]  hit_mat,
  output logic [N_WORDS*POS_W-1:0]  pos_flat,
  output logic                      sat_any
);
  logic [N_WORDS-1:0] sat_bits;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wd;
    assign wd = words[w*WORD_W +: WORD_W];
    assign sat_bits[w] = wd[0];
    assign pos_flat[w*POS_W +: POS_W] = wd[WORD_W-1 -: POS_W];
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
      assign hit_mat[t*N_WORDS + w] = wd[t+1];
    end
  end

  assign sat_any = |sat_bits;
endmodule

// File: rtl/jht_thr_counter.sv
module jht_thr_counter #(
  parameter int N_WORDS = 8,
  parameter int CNT_W   = 3,
  localparam int MAXV   = (1 << CNT_W) - 1
) (
  input  logic [N_WORDS-1:0] hits,
  input  logic               force_max,
  output logic [CNT_W-1:0]   cnt
);
  int sum;

  always_comb begin
    sum = 0;
    for (int i = 0; i < N_WORDS; i++) begin
      sum = sum + int'(hits[i]);
    end
    if (force_max || sum > MAXV) cnt = CNT_W'(MAXV);
    else                         cnt = CNT_W'(sum);
  end

  always_comb begin
    if (!force_max && hits == '0)
      assert_empty_zero_R3: assert (cnt == '0);
    if (!force_max && $countones(hits) >= MAXV)
      assert_clamp_top_R4: assert (cnt == CNT_W'(MAXV));
  end
endmodule

// File: rtl/jet_hit_tally.sv
module jet_hit_tally
  import jht_pkg::*;
#(
  parameter int N_WORDS = JHT_WORDS,
  parameter int N_THR   = JHT_THR,
  parameter int POS_W   = JHT_POS_W,
  parameter int CNT_W   = JHT_CNT_W,
  localparam int WORD_W = POS_W + N_THR + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [N_WORDS*WORD_W-1:0] in_words,
  output logic                      out_valid,
  output logic [N_THR*CNT_W-1:0]    out_counts,
  output logic                      out_sat,
  output logic [N_WORDS*POS_W-1:0]  out_pos
);
  logic [N_THR*N_WORDS-1:0] hit_mat;
  logic [N_WORDS*POS_W-1:0] pos_flat;
  logic                     sat_any;
  logic [N_THR*CNT_W-1:0]   cnt_next;

  jht_unpack #(.N_WORDS(N_WORDS), .N_THR(N_THR), .POS_W(POS_W)) u_unpack (
    .words   (in_words),
    .hit_mat (hit_mat),
    .pos_flat(pos_flat),
    .sat_any (sat_any)
  );

  for (genvar t = 0; t < N_THR; t++) begin : g_cnt
    jht_thr_counter #(.N_WORDS(N_WORDS), .CNT_W(CNT_W)) u_cnt (
      .hits     (hit_mat[t*N_WORDS +: N_WORDS]),
      .force_max(sat_any),
      .cnt      (cnt_next[t*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_counts <= '0;
      out_sat    <= 1'b0;
      out_pos    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_counts <= cnt_next;
        out_sat    <= sat_any;
        out_pos    <= pos_flat;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_counts == '0 && !out_sat && out_pos == '0));

  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_sat_all_max_R5: assert property (@(posedge clk) disable iff (rst)
    out_sat |-> (&out_counts));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      ($stable(out_counts) && $stable(out_sat) && $stable(out_pos)));
endmodule

// File: tb/jet_hit_tally_bench.sv
module jet_hit_tally_bench;
  localparam int NW = 8, NT = 8, PW = 2, CW = 3, WW = PW + NT + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [NW*WW-1:0]  in_words = '0;
  logic              out_valid;
  logic [NT*CW-1:0]  out_counts;
  logic              out_sat;
  logic [NW*PW-1:0]  out_pos;

  int compared = 0, mismatched = 0;
  logic             e_valid = 1'b0, e_sat = 1'b0;
  logic [NT*CW-1:0] e_counts = '0;
  logic [NW*PW-1:0] e_pos = '0;

  always #4 clk = ~clk;

  jet_hit_tally u_jet_hit_tally (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_counts(out_counts), .out_sat(out_sat), .out_pos(out_pos)
  );

  function automatic logic [WW-1:0] mk(int pos, int thr, int sat);
    return {PW'(pos), NT'(thr), 1'(sat)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    int c;
    bit s;
    if (rst) begin
      e_valid = 0; e_counts = '0; e_sat = 0; e_pos = '0;
      return;
    end
    e_valid = in_valid;
    if (!in_valid) return;
    s = 0;
    for (int w = 0; w < NW; w++) if (in_words[w*WW] == 1'b1) s = 1;
    e_sat = s;
    for (int k = 0; k < NT; k++) begin
      c = 0;
      for (int w = 0; w < NW; w++) if (in_words[w*WW + 1 + k] == 1'b1) c++;
      if (c > 7 || s) c = 7;
      e_counts[k*CW +: CW] = CW'(c);
    end
    for (int w = 0; w < NW; w++) e_pos[w*PW +: PW] = in_words[w*WW + WW - PW +: PW];
  endtask

  task automatic step(logic v, logic [NW*WW-1:0] wds, string req);
    @(negedge clk);
    in_valid = v;
    in_words = wds;
    @(posedge clk);
    model();
    #1;
    check({req, "/R2 valid"}, 32'(out_valid), 32'(e_valid));
    check({req, " counts"}, 32'(out_counts), 32'(e_counts));
    check({req, " sat"}, 32'(out_sat), 32'(e_sat));
    check({req, "/R6 pos"}, 32'(out_pos), 32'(e_pos));
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [NW*WW-1:0] f;
    rst = 1'b1;
    step(1'b1, '1, "R1 reset");
    step(1'b0, '0, "R1 reset");
    rst = 1'b0;
    // R3: one word per threshold-distinct pattern, staircase counts
    f = '0;
    for (int w = 0; w < NW; w++) f[w*WW +: WW] = mk(w % 4, (1 << w) - 1 + (1 << w), 0);
    step(1'b1, f, "R3 stair");
    // R3: single word, single bit
    f = '0; f[3*WW +: WW] = mk(0, 8'h10, 0);
    step(1'b1, f, "R3 single");
    // R4: all eight words pass all thresholds
    f = '0;
    for (int w = 0; w < NW; w++) f[w*WW +: WW] = mk(1, 8'hFF, 0);
    step(1'b1, f, "R4 clamp");
    // R7: only positions set, counts zero
    f = '0;
    for (int w = 0; w < NW; w++) f[w*WW +: WW] = mk(3, 0, 0);
    step(1'b1, f, "R7 pos only");
    // R8: idle cycles with changing words
    for (int i = 0; i < 4; i++) step(1'b0, {3{$urandom}}, "R8 hold");
    // R5: override alone, sat flag in each word in turn
    for (int s = 0; s < NW; s++) begin
      f = '0; f[s*WW +: WW] = mk(s % 4, 0, 1);
      step(1'b1, f, "R5 override");
    end
    // R4+R5 together: clamp and override in one frame
    for (int s = 0; s < NW; s++) begin
      f = '0;
      for (int w = 0; w < NW; w++) f[w*WW +: WW] = mk((w + s) % 4, 8'hFF, (w == s) ? 1 : 0);
      step(1'b1, f, "R5 clamp+override");
    end
    // back-to-back and gapped random frames
    for (int i = 0; i < 300; i++) begin
      f = '0;
      for (int w = 0; w < NW; w++)
        f[w*WW +: WW] = mk(int'($urandom % 4), int'($urandom % 256), (($urandom % 16) == 0) ? 1 : 0);
      step(($urandom % 4) != 0, f, "R3 random");
    end
    // R1: reset in mid-stream
    rst = 1'b1;
    step(1'b1, '1, "R1 midreset");
    rst = 1'b0;
    step(1'b0, '1, "R8 after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule